// File: doc/BRIEF.md
# Shift-Register Reload Clock Divider

This block divides a clock using shift-register counters instead of binary counters. It is meant to serve as the reference and feedback dividers of a frequency synthesiser. Each divider shifts its state left on every input clock and feeds the inverted parity of a fixed tap set back into bit 0. When the state reaches all-ones, the divider loads its programmed reload value and toggles its output.

The state of a divider runs along a fixed chain that ends at all-ones. The reload value picks how far along that chain it starts. To divide by D, software writes the chain state that lies D-1 steps before all-ones. The block has two such dividers: a 6-bit one with divisors 1 to 64 and an 8-bit one with divisors 2 to 256. A third path is a two-stage post-divider. Its two stage factors are packed into one register field pair, each field stored as 8 minus the factor.

All three paths run on the input clock. Software programs them through a small write port.

Top module: `lfsr_clkdiv_top`

## Requirements
- R1: Each divider state steps as a left shift. Bit 0 takes the inverted XOR of the tap bits: bits 5 and 4 for the 6-bit divider, and bits 7, 3, 2 and 1 for the 8-bit divider. The all-zero state steps to all-ones. For example, the 6-bit chain runs 0x01, 0x03, 0x07, 0x0f, 0x1f, 0x3e, 0x3d.
- R2: When a divider state is all-ones, the next clock loads the reload register and toggles that divider's output. On every other clock the output holds. Each output half-period therefore lasts D input clocks, where D-1 is the number of steps from the reload value to all-ones.
- R3: On the 6-bit output, reload values 0x3f, 0x00, 0x20, 0x10, 0x28 and 0x14 give half-periods of 1 to 6 clocks, and 0x01 gives 64. Every divisor from 1 to 64 can be reached.
- R4: On the 8-bit output, reload values 0x00, 0x80, 0xc0, 0xe0 and 0xf0 give half-periods of 2 to 6 clocks, and 0x01 gives 256. Every divisor from 2 to 256 can be reached.
- R5: A write with `cfg_we` high selects its target with `cfg_sel`:
  - 0 writes `cfg_wdata[5:0]` to the 6-bit reload register.
  - 1 writes `cfg_wdata[7:0]` to the 8-bit reload register.
  - 2 writes `cfg_wdata[5:0]` to the post-divider register.
  - 3 changes nothing.

  A write to one target leaves the output periods of the other paths unchanged.
- R6: A reload write does not shorten or stretch the half-period in progress. The new divisor applies from the next all-ones event onward.
- R7: In the post-divider register, bits [5:3] hold 8-p1 and bits [2:0] hold 8-p2. The post output toggles every p1*p2 input clocks.
- R8: A post-divider write does not alter the half-period in progress. The new factors apply from the next post output toggle.
- R9: While `rst` is high, all outputs are low and each divider runs at divisor 1. Both reload registers reset to all-ones, and the post register resets to 0x3f. All three outputs go high on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_sel | input | 2 | Write target: 0 6-bit reload, 1 8-bit reload, 2 post factors, 3 none |
| cfg_wdata | input | 8 | Write data |
| m_clk_o | output | 1 | 6-bit divider output, toggling every D clocks |
| n_clk_o | output | 1 | 8-bit divider output, toggling every D clocks |
| post_clk_o | output | 1 | Post-divider output, toggling every p1*p2 clocks |

## Verification
The bench measures the gap between output toggles for every divisor of both shift-register dividers. It uses the stated reload values as directed cases. A wrong tap set or a mishandled all-zero state would show up as wrong gaps for whole ranges of divisors. The extreme divisors (1, 2, 64, 256) catch an off-by-one in the terminal detection.

Writes that land in the middle of a half-period catch a design that reloads at once and so emits a short pulse. Random legal post-factor pairs, plus the 1x1 and 8x8 corners, catch swapped fields or an inverted encoding. Writes with the unused select check that no other path is disturbed.

// File: rtl/lfsr_clkdiv_pkg.sv
package lfsr_clkdiv_pkg;

    localparam int M_W        = 6;
    localparam int N_W        = 8;
    localparam int CFG_W      = 8;
    localparam int PD_FW      = 3;
    localparam int PD_STAGES  = 2;
    localparam int PD_FACT_W  = PD_FW + 1;

    // Feedback tap masks (inverted parity of these bits enters bit 0).
    localparam logic [M_W-1:0] M_TAPS = 6'b11_0000;
    localparam logic [N_W-1:0] N_TAPS = 8'b1000_1110;

    typedef enum logic [1:0] {
        SEL_M    = 2'd0,
        SEL_N    = 2'd1,
        SEL_POST = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // First stage field sits in the upper three bits.
    typedef struct packed {
        logic [PD_FW-1:0] f_first;
        logic [PD_FW-1:0] f_second;
    } post_cfg_t;

    localparam post_cfg_t POST_RST = '{f_first: '1, f_second: '1};

    function automatic logic [PD_FACT_W-1:0] field_to_factor(input logic [PD_FW-1:0] f);
        return PD_FACT_W'(8) - {1'b0, f};
    endfunction

endpackage

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div #(
    parameter int             W          = 6,
    parameter logic [W-1:0]   TAPS       = 6'b11_0000,
    parameter logic [W-1:0]   RST_RELOAD = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic         div_o,
    output logic         term_o,
    output logic [W-1:0] state_o,
    output logic [W-1:0] reload_o
);
    localparam logic [W-1:0] TERM = '1;

    logic [W-1:0] state_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] nxt;
    logic         fb;
    logic         out_q;
    logic         at_term;

    assign at_term = (state_q == TERM);

    always_comb begin
        fb = ~^(state_q & TAPS);
        if (state_q == '0)
            nxt = TERM;
        else
            nxt = {state_q[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= RST_RELOAD;
            state_q  <= TERM;
            out_q    <= 1'b0;
        end else begin
            if (load_en)
                reload_q <= load_val;
            if (at_term) begin
                state_q <= reload_q;
                out_q   <= ~out_q;
            end else begin
                state_q <= nxt;
            end
        end
    end

    assign div_o    = out_q;
    assign term_o   = at_term;
    assign state_o  = state_q;
    assign reload_o = reload_q;
endmodule

// File: rtl/post_div_stage.sv
module post_div_stage #(
    parameter int CW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [CW:0] factor,
    output logic        tick
);
    logic [CW-1:0] cnt_q;

    assign tick = en && ({1'b0, cnt_q} == (factor - (CW+1)'(1)));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/post_divider.sv
module post_divider
    import lfsr_clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_en,
    input  post_cfg_t load_val,
    output logic      div_o,
    output logic      tick_o,
    output post_cfg_t cfg_o,
    output post_cfg_t act_o
);
    post_cfg_t cfg_q;
    post_cfg_t act_q;
    logic      out_q;

    logic [PD_FACT_W-1:0] stage_fact [PD_STAGES];
    logic                 stage_en   [PD_STAGES];
    logic                 stage_tick [PD_STAGES];
    logic                 done;

    assign stage_fact[0] = field_to_factor(act_q.f_first);
    assign stage_fact[1] = field_to_factor(act_q.f_second);

    for (genvar s = 0; s < PD_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign stage_en[s] = 1'b1;
        end else begin : g_tail
            assign stage_en[s] = stage_tick[s-1];
        end
        post_div_stage #(.CW(PD_FW)) i_stage (
            .clk    (clk),
            .rst    (rst),
            .en     (stage_en[s]),
            .factor (stage_fact[s]),
            .tick   (stage_tick[s])
        );
    end

    assign done = stage_tick[PD_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= POST_RST;
            act_q <= POST_RST;
            out_q <= 1'b0;
        end else begin
            if (load_en)
                cfg_q <= load_val;
            if (done) begin
                act_q <= cfg_q;
                out_q <= ~out_q;
            end
        end
    end

    assign div_o  = out_q;
    assign tick_o = done;
    assign cfg_o  = cfg_q;
    assign act_o  = act_q;
endmodule

// File: rtl/lfsr_clkdiv_top.sv
module lfsr_clkdiv_top
    import lfsr_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             m_clk_o,
    output logic             n_clk_o,
    output logic             post_clk_o
);
    cfg_sel_e sel;
    logic     m_ld, n_ld, p_ld;

    logic           m_term, n_term, post_tick;
    logic [M_W-1:0] m_state, m_reload;
    logic [N_W-1:0] n_state, n_reload;
    post_cfg_t      post_cfg, post_act;

    assign sel  = cfg_sel_e'(cfg_sel);
    assign m_ld = cfg_we && (sel == SEL_M);
    assign n_ld = cfg_we && (sel == SEL_N);
    assign p_ld = cfg_we && (sel == SEL_POST);

    lfsr_reload_div #(.W(M_W), .TAPS(M_TAPS), .RST_RELOAD('1)) i_mdiv (
        .clk      (clk),
        .rst      (rst),
        .load_en  (m_ld),
        .load_val (cfg_wdata[M_W-1:0]),
        .div_o    (m_clk_o),
        .term_o   (m_term),
        .state_o  (m_state),
        .reload_o (m_reload)
    );

    lfsr_reload_div #(.W(N_W), .TAPS(N_TAPS), .RST_RELOAD('1)) i_ndiv (
        .clk      (clk),
        .rst      (rst),
        .load_en  (n_ld),
        .load_val (cfg_wdata[N_W-1:0]),
        .div_o    (n_clk_o),
        .term_o   (n_term),
        .state_o  (n_state),
        .reload_o (n_reload)
    );

    post_divider i_post (
        .clk      (clk),
        .rst      (rst),
        .load_en  (p_ld),
        .load_val (post_cfg_t'(cfg_wdata[2*PD_FW-1:0])),
        .div_o    (post_clk_o),
        .tick_o   (post_tick),
        .cfg_o    (post_cfg),
        .act_o    (post_act)
    );
endmodule

// File: rtl/lfsr_clkdiv_chk.sv
module lfsr_clkdiv_chk
    import lfsr_clkdiv_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           cfg_we,
    input logic [1:0]     cfg_sel,
    input logic           m_clk_o,
    input logic           n_clk_o,
    input logic           post_clk_o,
    input logic           m_term,
    input logic           n_term,
    input logic           post_tick,
    input logic [M_W-1:0] m_state,
    input logic [M_W-1:0] m_reload,
    input logic [N_W-1:0] n_state,
    input logic [N_W-1:0] n_reload,
    input post_cfg_t      post_cfg,
    input post_cfg_t      post_act
);
    // R1: shift behaviour and all-zero exit
    p_m_shift_r1: assert property (@(posedge clk) disable iff (rst)
        (!m_term && m_state != '0) |=> m_state[M_W-1:1] == $past(m_state[M_W-2:0]));
    p_n_shift_r1: assert property (@(posedge clk) disable iff (rst)
        (!n_term && n_state != '0) |=> n_state[N_W-1:1] == $past(n_state[N_W-2:0]));
    p_zero_exit_r1: assert property (@(posedge clk) disable iff (rst)
        (m_state == '0) |=> m_term);

    // R2: reload and toggle only at the terminal state
    p_m_reload_r2: assert property (@(posedge clk) disable iff (rst)
        m_term |=> m_state == $past(m_reload));
    p_n_reload_r2: assert property (@(posedge clk) disable iff (rst)
        n_term |=> n_state == $past(n_reload));
    p_m_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        m_term |=> m_clk_o != $past(m_clk_o));
    p_m_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !m_term |=> $stable(m_clk_o));
    p_n_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        n_term |=> n_clk_o != $past(n_clk_o));
    p_n_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !n_term |=> $stable(n_clk_o));

    // R5: unused select leaves every register alone
    p_sel_none_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(m_reload) && $stable(n_reload) && $stable(post_cfg)));

    // R7: post output moves only at the end of the stage chain
    p_post_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        post_tick |=> post_clk_o != $past(post_clk_o));
    p_post_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !post_tick |=> $stable(post_clk_o));

    // R8: active post factors change only at a toggle
    p_post_defer_r8: assert property (@(posedge clk) disable iff (rst)
        !post_tick |=> $stable(post_act));

    // R9: reset clears the outputs
    p_reset_out_r9: assert property (@(posedge clk)
        rst |=> (!m_clk_o && !n_clk_o && !post_clk_o));
endmodule

bind lfsr_clkdiv_top lfsr_clkdiv_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .m_clk_o    (m_clk_o),
    .n_clk_o    (n_clk_o),
    .post_clk_o (post_clk_o),
    .m_term     (m_term),
    .n_term     (n_term),
    .post_tick  (post_tick),
    .m_state    (m_state),
    .m_reload   (m_reload),
    .n_state    (n_state),
    .n_reload   (n_reload),
    .post_cfg   (post_cfg),
    .post_act   (post_act)
);

// File: tb/test_lfsr_clkdiv_top.sv
module test_lfsr_clkdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       m_clk_o, n_clk_o, post_clk_o;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    lfsr_clkdiv_top i_lfsr_clkdiv_top (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .m_clk_o    (m_clk_o),
        .n_clk_o    (n_clk_o),
        .post_clk_o (post_clk_o)
    );

    // Toggle monitor, sampled 2 ns after each rising edge
    int unsigned cyc = 0;
    logic [2:0]  prev = 3'b000;
    int unsigned last_t [3];
    int unsigned intv   [3];
    int unsigned tcnt   [3];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        if (!rst) begin
            for (int i = 0; i < 3; i++) begin
                logic v;
                v = (i == 0) ? m_clk_o : (i == 1) ? n_clk_o : post_clk_o;
                if (v != prev[i]) begin
                    intv[i]   = cyc - last_t[i];
                    last_t[i] = cyc;
                    tcnt[i]   = tcnt[i] + 1;
                end
            end
        end
        prev = {post_clk_o, n_clk_o, m_clk_o};
    end

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic wait_tog(input int idx, input int k);
        int unsigned target;
        target = tcnt[idx] + k;
        while (tcnt[idx] < target) @(negedge clk);
    endtask

    task automatic write_now(input logic [1:0] sel, input logic [7:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Program a value right after a toggle, let it settle, check the gap
    task automatic settle(input int idx, input logic [1:0] sel, input logic [7:0] data,
                          input int nwait, input int exp_v, input string req);
        wait_tog(idx, 1);
        write_now(sel, data);
        wait_tog(idx, nwait);
        check(req, int'(intv[idx]), exp_v);
    endtask

    // Reload value for divisor d, from the chain defined in R1
    function automatic logic [7:0] exp_reload(input int w, input int d);
        int s, taps, mask;
        taps = (w == 6) ? 'h30 : 'h8e;
        mask = (1 << w) - 1;
        s = 1;
        for (int i = 0; i < (1 << w) - d; i++) begin
            if (s == 0)
                s = mask;
            else
                s = ((s << 1) | (($countones(s & taps) % 2 == 0) ? 1 : 0)) & mask;
        end
        return 8'(s);
    endfunction

    function automatic logic [7:0] post_code(input int p1, input int p2);
        return {2'b00, 3'(8 - p1), 3'(8 - p2)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [7:0] m_tab [6] = '{8'h3f, 8'h00, 8'h20, 8'h10, 8'h28, 8'h14};
    logic [7:0] n_tab [5] = '{8'h00, 8'h80, 8'hc0, 8'he0, 8'hf0};

    initial begin
        void'($urandom(32'd20061210));
        for (int i = 0; i < 3; i++) begin
            last_t[i] = 0; intv[i] = 0; tcnt[i] = 0;
        end

        // R9: reset state and first toggles
        repeat (4) @(negedge clk);
        check("R9 m low in reset", int'(m_clk_o), 0);
        check("R9 n low in reset", int'(n_clk_o), 0);
        check("R9 post low in reset", int'(post_clk_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 m high after first edge", int'(m_clk_o), 1);
        check("R9 n high after first edge", int'(n_clk_o), 1);
        check("R9 post high after first edge", int'(post_clk_o), 1);
        wait_tog(0, 2); check("R9 m default divisor", int'(intv[0]), 1);
        wait_tog(1, 2); check("R9 n default divisor", int'(intv[1]), 1);
        wait_tog(2, 2); check("R9 post default divisor", int'(intv[2]), 1);

        // R3: stated 6-bit reload values
        for (int i = 0; i < 6; i++)
            settle(0, 2'd0, m_tab[i], 3, i + 1, "R3 stated M value");
        settle(0, 2'd0, 8'h01, 3, 64, "R3 M divisor 64");

        // R4: stated 8-bit reload values
        for (int i = 0; i < 5; i++)
            settle(1, 2'd1, n_tab[i], 3, i + 2, "R4 stated N value");
        settle(1, 2'd1, 8'h01, 3, 256, "R4 N divisor 256");

        // R1/R3: every 6-bit divisor
        for (int d = 1; d <= 64; d++)
            settle(0, 2'd0, exp_reload(6, d), 3, d, "R1 R3 M sweep");

        // R1/R4: every 8-bit divisor (old divisor always >= 2 after the first)
        for (int d = 2; d <= 256; d++)
            settle(1, 2'd1, exp_reload(8, d), (d == 2) ? 3 : 2, d, "R1 R4 N sweep");

        // R6: mid-interval reload write
        settle(0, 2'd0, exp_reload(6, 40), 3, 40, "R6 M setup");
        wait_tog(0, 1);
        repeat (10) @(negedge clk);
        write_now(2'd0, exp_reload(6, 5));
        wait_tog(0, 1); check("R6 interval in progress kept", int'(intv[0]), 40);
        wait_tog(0, 1); check("R6 new divisor next", int'(intv[0]), 5);

        // R7: post-divider corners and random legal pairs
        settle(2, 2'd2, post_code(1, 1), 3, 1, "R7 post 1x1");
        settle(2, 2'd2, post_code(8, 8), 3, 64, "R7 post 8x8");
        settle(2, 2'd2, post_code(8, 1), 3, 8, "R7 post 8x1");
        for (int k = 0; k < 24; k++) begin
            int p1, p2;
            p1 = 1 + int'($urandom % 8);
            p2 = 1 + int'($urandom % p1);
            settle(2, 2'd2, post_code(p1, p2), 3, p1 * p2, "R7 post random");
        end

        // R8: post write lands mid half-period
        settle(2, 2'd2, post_code(4, 4), 3, 16, "R8 post setup");
        wait_tog(2, 1);
        repeat (3) @(negedge clk);
        write_now(2'd2, post_code(2, 1));
        wait_tog(2, 1); check("R8 post interval kept", int'(intv[2]), 16);
        wait_tog(2, 1); check("R8 post new factors", int'(intv[2]), 2);

        // R5: unused select and cross-isolation
        settle(0, 2'd0, exp_reload(6, 7), 3, 7, "R5 M setup");
        settle(1, 2'd1, exp_reload(8, 9), 3, 9, "R5 N setup");
        settle(2, 2'd2, post_code(3, 2), 3, 6, "R5 post setup");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            write_now(2'd3, 8'($urandom));
        end
        wait_tog(0, 2); check("R5 sel 3 ignored by M", int'(intv[0]), 7);
        wait_tog(1, 2); check("R5 sel 3 ignored by N", int'(intv[1]), 9);
        wait_tog(2, 2); check("R5 sel 3 ignored by post", int'(intv[2]), 6);
        @(negedge clk);
        write_now(2'd0, exp_reload(6, 3));
        wait_tog(1, 3); check("R5 N unaffected by M write", int'(intv[1]), 9);
        wait_tog(2, 3); check("R5 post unaffected by M write", int'(intv[2]), 6);
        wait_tog(0, 3); check("R5 M took its write", int'(intv[0]), 3);

        finish_run();
    end
endmodule